// File: doc/BRIEF.md
# SPI Master Phase Sequencer

This block is the transaction engine of an SPI master. A transaction is a fixed sequence of phases: prepare, command, address, dummy, write-data, read-data and done. Each middle phase runs only when its bit in a 32-bit configuration word is set and its length is non-zero. A disabled phase takes no cycles. The same configuration word also sets chip-select timing around the transfer, gating of the serial clock during dummy cycles, and how many data lines are used. The line modes are single-line with a separate input pin, 3-wire with one shared pin, full duplex, dual, quad and octal.

A host writes the configuration word while the engine is idle and presents the command, address, write data and the four lengths. It then pulses `start_i`. Lengths are in bits, except the dummy length, which is in serial clock periods. Command, address and data values are right-aligned and go out most significant bit first. Each serial bit period is two system clocks: serial clock low, then serial clock high. Input lines are sampled at the end of the high half. The engine raises busy for the whole transaction and pulses done when it returns to idle.

Top module: `spi_phase_seq`

## Requirements
- R1: After reset the configuration word reads 0x8000_00C0 (command, CS setup and CS hold enabled). The engine is idle with busy low, done low, CS high, SCLK low, every output enable low, all data outputs low and the read buffer zero.
- R2: A configuration write while idle takes effect on the next cycle. A configuration write while busy is ignored and the stored word is unchanged.
- R3: After a start the engine spends exactly one cycle in prepare. It then runs the enabled phases in the order command, address, dummy, write-data, read-data, and spends one cycle in done. A phase whose enable bit is clear, or whose length is zero, takes no cycles. Each serial period is one cycle with SCLK low followed by one cycle with SCLK high. The enable bits are 31 command, 30 address, 29 dummy, 28 read-data and 27 write-data.
- R4: In the command, address and write-data phases, the low `len` bits of the value are driven most significant first. A new group of bits appears at the start of each serial period and is held through both halves.
- R5: CS is low throughout the command to read-data phases. In the prepare cycle CS is low only when bit 7 is set. In the done cycle CS is low only when bit 6 is set. CS is high whenever the engine is idle.
- R6: The dummy phase lasts `dummy_len_i` serial periods with all output enables low. SCLK pulses in its high halves unless bit 26 is set, in which case SCLK stays low while the periods are still counted.
- R7: In single-line mode, the read-data phase samples input line 1 at the end of each high half and shifts the bit into the read buffer at bit 0. After `len` bits the received word sits in `rd_data_o[len-1:0]`.
- R8: With bit 17 set (3-wire mode), single-line reads sample input line 0 instead of line 1.
- R9: With bit 0 set (full duplex), the write-data phase also samples input line 1 once per serial period into the read buffer.
- R10: Bit 4 (octal) puts every phase on 8 lines and bit 3 (quad) puts every phase on 4 lines, with octal taking priority. Line L-1 carries the most significant bit of each L-bit group, for both output and input.
- R11: Bits 14, 13 and 12 select 8, 4 or 2 lines for the data phases only, while command and address stay single-line. The higher line count wins when several of these bits are set.
- R12: Output enables are high on exactly the active lines during the command, address and write-data phases, and low in every other phase.
- R13: Busy is high from the cycle after the start through the done cycle. Done is high for exactly one cycle, the first idle cycle after the done phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_i | input | 32 | Configuration word to write |
| cfg_o | output | 32 | Stored configuration word |
| start_i | input | 1 | Start a transaction (accepted while idle) |
| cmd_i | input | CMD_W | Command value, right-aligned |
| cmd_len_i | input | $clog2(CMD_W+1) | Command length in bits |
| addr_i | input | ADDR_W | Address value, right-aligned |
| addr_len_i | input | $clog2(ADDR_W+1) | Address length in bits |
| dummy_len_i | input | DMY_LW | Dummy length in serial periods |
| data_len_i | input | $clog2(DW+1) | Write and read data length in bits |
| wr_data_i | input | DW | Write data, right-aligned |
| rd_data_o | output | DW | Read buffer |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock |
| cs_no | output | 1 | Chip select, active low |
| sd_i | input | 8 | Serial data inputs |
| sd_o | output | 8 | Serial data outputs |
| sd_oe_o | output | 8 | Serial data output enables |

## Verification
The hardest situations to reach from the ports are ones where one configuration bit quietly changes another phase. Examples are a CS setup or hold cycle that differs from the bus phase by a single cycle, dummy periods that are counted while SCLK is suppressed, and lane priority when several data-width bits are set together. The stimulus reaches these by running a series of complete transactions, each with its own configuration word. Each transaction combines phases with lengths that are not multiples of eight, and one combination sets an enabled phase to length zero. Input lines carry a pattern that changes every cycle, so sampling from the wrong line or in the wrong half-period changes the received word. A configuration write is issued in the middle of a transaction to show that it is ignored.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_PREP = 3'd1,
    PH_CMD  = 3'd2,
    PH_ADDR = 3'd3,
    PH_DMY  = 3'd4,
    PH_WR   = 3'd5,
    PH_RD   = 3'd6,
    PH_DONE = 3'd7
  } phase_e;

  localparam int NLANE     = 8;
  localparam int B_DUPLEX  = 0;
  localparam int B_QUAD    = 3;
  localparam int B_OCT     = 4;
  localparam int B_HOLD    = 6;
  localparam int B_SETUP   = 7;
  localparam int B_DDUAL   = 12;
  localparam int B_DQUAD   = 13;
  localparam int B_DOCT    = 14;
  localparam int B_3WIRE   = 17;
  localparam int B_DMYGATE = 26;
  localparam int B_WR      = 27;
  localparam int B_RD      = 28;
  localparam int B_DMY     = 29;
  localparam int B_ADDR    = 30;
  localparam int B_CMD     = 31;

  // first enabled phase after cur; idle after done
  function automatic phase_e next_phase(phase_e cur, logic [7:0] en);
    phase_e res;
    res = PH_IDLE;
    for (int i = 7; i >= 1; i--) begin
      if (i > int'(cur) && en[i]) res = phase_e'(3'(i));
    end
    return res;
  endfunction

  function automatic logic [3:0] lanes_ca(logic [31:0] c);
    if (c[B_OCT])       return 4'd8;
    else if (c[B_QUAD]) return 4'd4;
    else                return 4'd1;
  endfunction

  function automatic logic [3:0] lanes_dat(logic [31:0] c);
    if (c[B_OCT] || c[B_DOCT])        return 4'd8;
    else if (c[B_QUAD] || c[B_DQUAD]) return 4'd4;
    else if (c[B_DDUAL])              return 4'd2;
    else                              return 4'd1;
  endfunction

  function automatic logic [NLANE-1:0] lane_mask(logic [3:0] n);
    logic [NLANE:0] t;
    t = (9'd1 << n) - 9'd1;
    return t[NLANE-1:0];
  endfunction

endpackage

// File: rtl/spi_seq_cfg.sv
module spi_seq_cfg #(
  parameter logic [31:0] CFG_RST = 32'h8000_00C0
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_i,
  input  logic [31:0] data_i,
  input  logic        busy_i,
  output logic [31:0] word_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             word_o <= CFG_RST;
    else if (wr_i && !busy_i) word_o <= data_i;
  end

  // R2
  cfg_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(word_o));

endmodule

// File: rtl/spi_seq_fsm.sv
module spi_seq_fsm
  import spi_seq_pkg::*;
#(
  parameter int CLW = 4,
  parameter int ALW = 6,
  parameter int MLW = 8,
  parameter int DLW = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [31:0]    cfg_i,
  input  logic [CLW-1:0] cmd_len_i,
  input  logic [ALW-1:0] addr_len_i,
  input  logic [MLW-1:0] dummy_len_i,
  input  logic [DLW-1:0] data_len_i,
  input  logic [3:0]     lanes_i,
  output phase_e         ph_o,
  output logic           hph_o,
  output logic           adv_o,
  output phase_e         nxt_o,
  output logic           busy_o,
  output logic           done_o
);

  localparam int RW0 = (ALW > DLW) ? ALW : DLW;
  localparam int RW1 = (RW0 > MLW) ? RW0 : MLW;
  localparam int RW  = (RW1 > 4) ? RW1 : 4;

  phase_e         ph;
  logic           hph;
  logic [RW-1:0]  rem, nlen;
  logic [CLW-1:0] c_len;
  logic [ALW-1:0] a_len;
  logic [MLW-1:0] m_len;
  logic [DLW-1:0] d_len;
  logic [7:0]     en;
  logic           beat_end;
  phase_e         nxt;

  always_comb begin
    en = '0;
    en[int'(PH_PREP)] = 1'b1;
    en[int'(PH_CMD)]  = cfg_i[B_CMD]  && (c_len != '0);
    en[int'(PH_ADDR)] = cfg_i[B_ADDR] && (a_len != '0);
    en[int'(PH_DMY)]  = cfg_i[B_DMY]  && (m_len != '0);
    en[int'(PH_WR)]   = cfg_i[B_WR]   && (d_len != '0);
    en[int'(PH_RD)]   = cfg_i[B_RD]   && (d_len != '0);
    en[int'(PH_DONE)] = 1'b1;
  end

  assign nxt      = next_phase(ph, en);
  assign beat_end = hph && (ph inside {PH_CMD, PH_ADDR, PH_DMY, PH_WR, PH_RD});
  assign adv_o    = (ph == PH_PREP) || (ph == PH_DONE) ||
                    (beat_end && (rem <= RW'(lanes_i)));

  always_comb begin
    unique case (nxt)
      PH_CMD:       nlen = RW'(c_len);
      PH_ADDR:      nlen = RW'(a_len);
      PH_DMY:       nlen = RW'(m_len);
      PH_WR, PH_RD: nlen = RW'(d_len);
      default:      nlen = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph     <= PH_IDLE;
      hph    <= 1'b0;
      rem    <= '0;
      c_len  <= '0;
      a_len  <= '0;
      m_len  <= '0;
      d_len  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= (ph == PH_DONE);
      if (ph == PH_IDLE) begin
        if (start_i) begin
          ph    <= PH_PREP;
          hph   <= 1'b0;
          c_len <= cmd_len_i;
          a_len <= addr_len_i;
          m_len <= dummy_len_i;
          d_len <= data_len_i;
        end
      end else if (adv_o) begin
        ph  <= nxt;
        hph <= 1'b0;
        rem <= nlen;
      end else begin
        hph <= ~hph;
        if (beat_end) rem <= rem - RW'(lanes_i);
      end
    end
  end

  assign ph_o   = ph;
  assign hph_o  = hph;
  assign nxt_o  = nxt;
  assign busy_o = (ph != PH_IDLE);

  // R13
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R13
  busy_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R3
  phase_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph != PH_IDLE && ph != PH_DONE) |=> (ph >= $past(ph)));

endmodule

// File: rtl/spi_seq_data.sv
module spi_seq_data
  import spi_seq_pkg::*;
#(
  parameter int CMD_W  = 8,
  parameter int ADDR_W = 32,
  parameter int DW     = 32,
  parameter int CLW    = 4,
  parameter int ALW    = 6,
  parameter int DLW    = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CLW-1:0]    cmd_len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ALW-1:0]    addr_len_i,
  input  logic [DW-1:0]     wdat_i,
  input  logic [DLW-1:0]    data_len_i,
  input  phase_e            ph_i,
  input  logic              hph_i,
  input  logic              adv_i,
  input  phase_e            nxt_i,
  input  logic [3:0]        lanes_i,
  input  logic              duplex_i,
  input  logic              three_i,
  input  logic [NLANE-1:0]  sd_i,
  output logic [NLANE-1:0]  sd_o,
  output logic [DW-1:0]     rd_o
);

  localparam int SW0 = (ADDR_W > DW) ? ADDR_W : DW;
  localparam int SW  = (SW0 > CMD_W) ? SW0 : CMD_W;

  logic [CMD_W-1:0]  cmd_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DW-1:0]     wdat_q;
  logic [CLW-1:0]    c_len;
  logic [ALW-1:0]    a_len;
  logic [DLW-1:0]    d_len;
  logic [SW-1:0]     sh;
  logic              beat_end, out_ph, smp;
  logic [3:0]        in_n;
  logic [NLANE-1:0]  in_bits, top;

  assign beat_end = hph_i && (ph_i inside {PH_CMD, PH_ADDR, PH_DMY, PH_WR, PH_RD});
  assign out_ph   = ph_i inside {PH_CMD, PH_ADDR, PH_WR};
  assign smp      = beat_end && ((ph_i == PH_RD) || (ph_i == PH_WR && duplex_i));
  assign in_n     = (ph_i == PH_WR) ? 4'd1 : lanes_i;

  always_comb begin
    if (in_n == 4'd1) in_bits = {{(NLANE-1){1'b0}}, three_i ? sd_i[0] : sd_i[1]};
    else              in_bits = sd_i & lane_mask(in_n);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q  <= '0;
      addr_q <= '0;
      wdat_q <= '0;
      c_len  <= '0;
      a_len  <= '0;
      d_len  <= '0;
      sh     <= '0;
      rd_o   <= '0;
    end else if (ph_i == PH_IDLE) begin
      if (start_i) begin
        cmd_q  <= cmd_i;
        addr_q <= addr_i;
        wdat_q <= wdat_i;
        c_len  <= cmd_len_i;
        a_len  <= addr_len_i;
        d_len  <= data_len_i;
        rd_o   <= '0;
      end
    end else begin
      if (adv_i) begin
        unique case (nxt_i)
          PH_CMD:  sh <= SW'(cmd_q)  << (SW - int'(c_len));
          PH_ADDR: sh <= SW'(addr_q) << (SW - int'(a_len));
          PH_WR:   sh <= SW'(wdat_q) << (SW - int'(d_len));
          default: sh <= sh;
        endcase
      end else if (beat_end && out_ph) begin
        sh <= sh << lanes_i;
      end
      if (smp) rd_o <= (rd_o << in_n) | DW'(in_bits);
    end
  end

  assign top  = sh[SW-1 -: NLANE];
  assign sd_o = out_ph ? (top >> (4'd8 - lanes_i)) : '0;

endmodule

// File: rtl/spi_phase_seq.sv
module spi_phase_seq
  import spi_seq_pkg::*;
#(
  parameter int          CMD_W   = 8,
  parameter int          ADDR_W  = 32,
  parameter int          DW      = 32,
  parameter int          DMY_LW  = 8,
  parameter logic [31:0] CFG_RST = 32'h8000_00C0,
  localparam int         CLW     = $clog2(CMD_W + 1),
  localparam int         ALW     = $clog2(ADDR_W + 1),
  localparam int         DLW     = $clog2(DW + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [31:0]       cfg_i,
  output logic [31:0]       cfg_o,
  input  logic              start_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CLW-1:0]    cmd_len_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ALW-1:0]    addr_len_i,
  input  logic [DMY_LW-1:0] dummy_len_i,
  input  logic [DLW-1:0]    data_len_i,
  input  logic [DW-1:0]     wr_data_i,
  output logic [DW-1:0]     rd_data_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_no,
  input  logic [7:0]        sd_i,
  output logic [7:0]        sd_o,
  output logic [7:0]        sd_oe_o
);

  phase_e     ph, nxt;
  logic       hph, adv;
  logic [3:0] lanes;

  spi_seq_cfg #(.CFG_RST(CFG_RST)) u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_i),
    .busy_i (busy_o),
    .word_o (cfg_o)
  );

  always_comb begin
    unique case (ph)
      PH_CMD, PH_ADDR: lanes = lanes_ca(cfg_o);
      PH_WR, PH_RD:    lanes = lanes_dat(cfg_o);
      default:         lanes = 4'd1;
    endcase
  end

  spi_seq_fsm #(.CLW(CLW), .ALW(ALW), .MLW(DMY_LW), .DLW(DLW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .cfg_i       (cfg_o),
    .cmd_len_i   (cmd_len_i),
    .addr_len_i  (addr_len_i),
    .dummy_len_i (dummy_len_i),
    .data_len_i  (data_len_i),
    .lanes_i     (lanes),
    .ph_o        (ph),
    .hph_o       (hph),
    .adv_o       (adv),
    .nxt_o       (nxt),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  spi_seq_data #(
    .CMD_W(CMD_W), .ADDR_W(ADDR_W), .DW(DW),
    .CLW(CLW), .ALW(ALW), .DLW(DLW)
  ) u_data (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .cmd_i      (cmd_i),
    .cmd_len_i  (cmd_len_i),
    .addr_i     (addr_i),
    .addr_len_i (addr_len_i),
    .wdat_i     (wr_data_i),
    .data_len_i (data_len_i),
    .ph_i       (ph),
    .hph_i      (hph),
    .adv_i      (adv),
    .nxt_i      (nxt),
    .lanes_i    (lanes),
    .duplex_i   (cfg_o[B_DUPLEX]),
    .three_i    (cfg_o[B_3WIRE]),
    .sd_i       (sd_i),
    .sd_o       (sd_o),
    .rd_o       (rd_data_o)
  );

  logic bus_ph;
  assign bus_ph  = ph inside {PH_CMD, PH_ADDR, PH_DMY, PH_WR, PH_RD};
  assign sclk_o  = bus_ph && hph && !(ph == PH_DMY && cfg_o[B_DMYGATE]);
  assign cs_no   = !(bus_ph || (ph == PH_PREP && cfg_o[B_SETUP]) ||
                     (ph == PH_DONE && cfg_o[B_HOLD]));
  assign sd_oe_o = (ph inside {PH_CMD, PH_ADDR, PH_WR}) ? lane_mask(lanes) : '0;

  // R5
  cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no);
  // R3
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !sclk_o);
  // R12
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o || ph == PH_RD || ph == PH_DMY) |-> (sd_oe_o == '0));
  // R4
  sd_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sd_oe_o == '0) |-> (sd_o == '0));

endmodule

// File: tb/spi_phase_seq_test.sv
module spi_phase_seq_test;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_wr_i = 1'b0;
  logic [31:0] cfg_i = '0;
  logic [31:0] cfg_o;
  logic        start_i = 1'b0;
  logic [7:0]  cmd_i = '0;
  logic [3:0]  cmd_len_i = '0;
  logic [31:0] addr_i = '0;
  logic [5:0]  addr_len_i = '0;
  logic [7:0]  dummy_len_i = '0;
  logic [5:0]  data_len_i = '0;
  logic [31:0] wr_data_i = '0;
  logic [31:0] rd_data_o;
  logic        busy_o, done_o, sclk_o, cs_no;
  logic [7:0]  sd_i = '0;
  logic [7:0]  sd_o, sd_oe_o;

  int n_cmp = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  spi_phase_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .cfg_wr_i(cfg_wr_i), .cfg_i(cfg_i), .cfg_o(cfg_o),
    .start_i(start_i), .cmd_i(cmd_i), .cmd_len_i(cmd_len_i), .addr_i(addr_i),
    .addr_len_i(addr_len_i), .dummy_len_i(dummy_len_i), .data_len_i(data_len_i),
    .wr_data_i(wr_data_i), .rd_data_o(rd_data_o), .busy_o(busy_o), .done_o(done_o),
    .sclk_o(sclk_o), .cs_no(cs_no), .sd_i(sd_i), .sd_o(sd_o), .sd_oe_o(sd_oe_o)
  );

  int     qv[$];
  bit     qd[$];
  longint mrx;

  function automatic int pat(int j);
    return ((j * 53 + 29) ^ (j >> 2)) & 255;
  endfunction

  task automatic chk(string tag, longint act, longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(bit cs, bit sck, int oe, int sdo, bit bsy, bit dn, bit dmy);
    qv.push_back((int'(dn) << 19) | (int'(bsy) << 18) | (int'(cs) << 17) |
                 (int'(sck) << 16) | ((oe & 255) << 8) | (sdo & 255));
    qd.push_back(dmy);
  endtask

  task automatic emit_out(longint val, int len, int l, bit dup);
    int m;
    m = (1 << l) - 1;
    for (int b = 0; b < len / l; b++) begin
      int bits;
      bits = int'((val >> (len - l * (b + 1))) & m);
      push(0, 0, m, bits, 1, 0, 0);
      if (dup) mrx = ((mrx << 1) | ((pat(qv.size()) >> 1) & 1)) & 64'hFFFF_FFFF;
      push(0, 1, m, bits, 1, 0, 0);
    end
  endtask

  task automatic build(logic [31:0] c, int cmd, int clen, longint addr, int alen,
                       int mlen, longint wd, int dlen);
    int lc, ld;
    qv.delete();
    qd.delete();
    mrx = 0;
    lc = c[4] ? 8 : (c[3] ? 4 : 1);
    ld = (c[4] || c[14]) ? 8 : ((c[3] || c[13]) ? 4 : (c[12] ? 2 : 1));
    push(!c[7], 0, 0, 0, 1, 0, 0);
    if (c[31] && clen > 0) emit_out(cmd, clen, lc, 0);
    if (c[30] && alen > 0) emit_out(addr, alen, lc, 0);
    if (c[29] && mlen > 0)
      for (int b = 0; b < mlen; b++) begin
        push(0, 0, 0, 0, 1, 0, 1);
        push(0, !c[26], 0, 0, 1, 0, 1);
      end
    if (c[27] && dlen > 0) emit_out(wd, dlen, ld, c[0]);
    if (c[28] && dlen > 0)
      for (int b = 0; b < dlen / ld; b++) begin
        int p, bits;
        push(0, 0, 0, 0, 1, 0, 0);
        p = pat(qv.size());
        if (ld == 1) bits = c[17] ? (p & 1) : ((p >> 1) & 1);
        else         bits = p & ((1 << ld) - 1);
        mrx = ((mrx << ld) | bits) & 64'hFFFF_FFFF;
        push(0, 1, 0, 0, 1, 0, 0);
      end
    push(!c[6], 0, 0, 0, 1, 0, 0);
    push(1, 0, 0, 0, 0, 1, 0);
    push(1, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic write_cfg(logic [31:0] c);
    cfg_i = c;
    cfg_wr_i = 1'b1;
    @(negedge clk_i);
    cfg_wr_i = 1'b0;
  endtask

  task automatic run_txn(logic [31:0] c, int cmd, int clen, longint addr, int alen,
                         int mlen, longint wd, int dlen, string tag_o, string tag_i,
                         bit poke);
    write_cfg(c);
    build(c, cmd, clen, addr, alen, mlen, wd, dlen);
    cmd_i = cmd[7:0];
    cmd_len_i = clen[3:0];
    addr_i = addr[31:0];
    addr_len_i = alen[5:0];
    dummy_len_i = mlen[7:0];
    wr_data_i = wd[31:0];
    data_len_i = dlen[5:0];
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int j = 0; j < qv.size(); j++) begin
      int e;
      e = qv[j];
      chk("R5 cs", cs_no, (e >> 17) & 1);
      chk(qd[j] ? "R6 sclk" : "R3 sclk", sclk_o, (e >> 16) & 1);
      chk("R12 oe", sd_oe_o, (e >> 8) & 255);
      chk({tag_o, " sd_o"}, sd_o, e & 255);
      chk("R13 busy", busy_o, (e >> 18) & 1);
      chk("R13 done", done_o, (e >> 19) & 1);
      sd_i = pat(j);
      cfg_wr_i = poke && (j == 2);
      cfg_i = 32'h0000_5A5A;
      @(negedge clk_i);
      cfg_wr_i = 1'b0;
    end
    if (tag_i != "") chk({tag_i, " rd_data"}, rd_data_o, mrx);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 cfg", cfg_o, 32'h8000_00C0);
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 cs", cs_no, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 oe", sd_oe_o, 0);
    chk("R1 sd_o", sd_o, 0);
    chk("R1 rd_data", rd_data_o, 0);

    // R4 default word, command only, with a configuration write mid-transfer (R2)
    run_txn(32'h8000_00C0, 'hA5, 8, 0, 0, 0, 0, 0, "R4", "", 1'b1);
    chk("R2 cfg held while busy", cfg_o, 32'h8000_00C0);
    write_cfg(32'h1234_0000);
    chk("R2 cfg written idle", cfg_o, 32'h1234_0000);

    // R7 single-line read with dummy, CS setup and hold off
    run_txn(32'hF000_0000, 'h3B, 8, 'h123456, 24, 3, 0, 16, "R4", "R7", 1'b0);
    // R8 3-wire read, R6 gated dummy clock, setup on
    run_txn(32'hF402_0080, 'h0B, 8, 'hABC, 12, 4, 0, 8, "R4", "R8", 1'b0);
    // R9 full duplex write with hold
    run_txn(32'h8800_0041, 'h06, 8, 0, 0, 0, 'hC3A5, 16, "R4", "R9", 1'b0);
    // R10 quad on every phase
    run_txn(32'hF800_00C8, 'hEB, 8, 'h00FF00, 24, 2, 'h1234, 16, "R10", "R10", 1'b0);
    // R10 octal on every phase
    run_txn(32'hD800_0010, 'h5A, 8, 'hDEAD_BEEF, 32, 0, 'h0F1E_2D3C, 32, "R10", "R10", 1'b0);
    // R11 dual data, single-line command
    run_txn(32'h9800_1000, 'h32, 8, 0, 0, 0, 'hB7, 8, "R11", "R11", 1'b0);
    // R11 quad beats dual
    run_txn(32'h9000_3000, 'h77, 7, 0, 0, 0, 0, 16, "R11", "R11", 1'b0);
    // R11 octal beats quad and dual
    run_txn(32'h9000_7000, 'h01, 1, 0, 0, 0, 0, 24, "R11", "R11", 1'b0);
    // R3 no phases enabled: prepare and done only
    run_txn(32'h0000_0000, 'hFF, 8, 0, 0, 0, 0, 0, "R3", "", 1'b0);
    // R3 enabled address with zero length is skipped
    run_txn(32'hC000_00C0, 'h9F, 8, 'h55, 0, 0, 0, 0, "R3", "", 1'b0);
    // R3 odd lengths, dummy and write without command
    run_txn(32'h6800_0040, 0, 0, 'h5, 3, 1, 'h1B, 5, "R3", "", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule